// File: doc/BRIEF.md
# Four-Pin Microcontroller I/O Port

This block is the general-purpose I/O port of a small microcontroller. It has four pins. Software writes an output latch from the data bus. A separate instruction strobe loads a direction register from the accumulator, and that register cannot be read back. A port read always returns the synchronized pin levels, never the latch. A pin that software drives high but that something outside holds low therefore reads as 0.

Each pin's driver enable and driven value come from a fixed precedence. Peripheral overrides from the comparator, the timer clock input and the instruction-clock output rank above the direction bit. Pin 3 is input-only. The block also produces the weak pull-up controls and a wake-on-change pulse for use during sleep. Pull-ups and wake-on-change act on pins 0, 1 and 3 as one group. A reset-pin mode changes how pin 3 takes part in both.

Top module: `mcu_port_ctrl`

## Requirements
- R1: `rd_data` is `{4'b0000, p}`, where p is the level on `pin_in[3:0]` two rising edges earlier. This holds whatever the direction bits are, so a pin driven high but held low reads 0. Bits 7:4 are always 0.
- R2: A cycle with `lat_we` high stores `lat_wdata[3:0]` into the output latch. The latch keeps that value until the next write. The new value appears on `pin_out` after the second rising edge that follows the write cycle, and is not yet there after the first.
- R3: A cycle with `dir_we` high loads `dir_wdata[3:0]` into the direction register. For pins 0 to 2 with no override active, a direction bit of 1 gives `pin_oe`=0. A direction bit of 0 gives `pin_oe`=1, with `pin_out` equal to the latch bit.
- R4: Synchronous reset `rst` sets every direction bit to 1 and the latch to 0. It sets `pin_oe` to 0000 and `wake` to 0.
- R5: `pin_oe[3]` is 0 at all times, even when direction bit 3 is 0.
- R6: `cmp_pos_en` high forces `pin_oe[0]` to 0. `cmp_neg_en` high forces `pin_oe[1]` to 0. Each override takes effect one rising edge after the enable is applied.
- R7: Pin 2 takes its drive from the first active source in this order. First is `fosc4_en`, which drives `fosc4_val`. Next is `cmp_out_en`, which drives `cmp_out`. Next is `t0ck_en`, which turns the driver off. Last is the direction bit. The result shows on the pin one rising edge later.
- R8: `pin_pullup` bits 0, 1 and 3 are 1 when `pullup_en_n` is 0. `pin_pullup[2]` is always 0. `mclr_mode` high forces `pin_pullup[3]` to 1.
- R9: A cycle with `rd_en` high snapshots the synchronized pins. With `sleep`=1 and `wake_en_n`=0, suppose a pin among 0, 1 and 3 changes away from the snapshot. `wake` is then high for exactly one cycle, after the third rising edge that follows the change. A change on pin 2 never wakes. Pin 3 is left out of the check while `mclr_mode` is 1.
- R10: `wake` stays 0 while `sleep` is 0 or `wake_en_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_we | input | 1 | Direction register load strobe |
| dir_wdata | input | 8 | Accumulator value for direction load |
| lat_we | input | 1 | Output latch write strobe |
| lat_wdata | input | 8 | Data bus value for latch write |
| rd_en | input | 1 | Port read strobe (updates wake snapshot) |
| rd_data | output | 8 | Port read value |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables, 1 = driven |
| pin_pullup | output | 4 | Weak pull-up enables |
| pullup_en_n | input | 1 | Group pull-up enable, active low |
| wake_en_n | input | 1 | Group wake-on-change enable, active low |
| mclr_mode | input | 1 | Pin 3 used as reset pin |
| sleep | input | 1 | Core is sleeping |
| cmp_pos_en | input | 1 | Comparator uses pin 0 as input |
| cmp_neg_en | input | 1 | Comparator uses pin 1 as input |
| cmp_out_en | input | 1 | Comparator output routed to pin 2 |
| cmp_out | input | 1 | Comparator output value |
| fosc4_en | input | 1 | Instruction clock output on pin 2 |
| fosc4_val | input | 1 | Instruction clock output value |
| t0ck_en | input | 1 | Timer clock input on pin 2 |
| wake | output | 1 | One-cycle wake request |

## Verification
A corrupted direction or latch bit shows up at `pin_oe` or `pin_out` two edges after the write. A wrong precedence term shows up one edge after the override changes. Because reads loop the pin back, a wrong driven value also shows up in `rd_data` two edges later. A stale or wrong wake snapshot appears as a missing or extra `wake` pulse exactly three edges after a pin changes. A detector that holds its level instead of pulsing shows a second high cycle at the edge that follows.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int NPINS  = 4;
    localparam int REG_W  = 8;
    localparam int HI_W   = REG_W - NPINS;

    // Group mask of pins that take part in pull-up and wake-on-change
    localparam logic [NPINS-1:0] GROUP_MASK = 4'b1011;
    localparam int MCLR_PIN = 3;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    typedef enum logic [1:0] {
        P2_CLKOUT = 2'd0,
        P2_CMPOUT = 2'd1,
        P2_TMRIN  = 2'd2,
        P2_DIR    = 2'd3
    } p2_src_e;

    function automatic p2_src_e p2_pick(input logic clk_en, input logic cmp_en,
                                        input logic tmr_en);
        if (clk_en)      return P2_CLKOUT;
        else if (cmp_en) return P2_CMPOUT;
        else if (tmr_en) return P2_TMRIN;
        else             return P2_DIR;
    endfunction

    function automatic pin_drv_t dir_drive(input logic dir_bit, input logic lat_bit);
        pin_drv_t d;
        d.oe  = ~dir_bit;
        d.val = lat_bit;
        return d;
    endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux
    import pio_pkg::*;
(
    input  logic [NPINS-1:0]     dir_bits,
    input  logic [NPINS-1:0]     lat_bits,
    input  logic                 cmp_pos_en,
    input  logic                 cmp_neg_en,
    input  logic                 cmp_out_en,
    input  logic                 cmp_out,
    input  logic                 fosc4_en,
    input  logic                 fosc4_val,
    input  logic                 t0ck_en,
    output pin_drv_t [NPINS-1:0] drv
);
    p2_src_e p2_src;

    always_comb begin
        p2_src = p2_pick(fosc4_en, cmp_out_en, t0ck_en);

        // Pin 0: comparator positive input above direction
        drv[0] = cmp_pos_en ? pin_drv_t'{oe: 1'b0, val: 1'b0}
                            : dir_drive(dir_bits[0], lat_bits[0]);

        // Pin 1: comparator negative input above direction
        drv[1] = cmp_neg_en ? pin_drv_t'{oe: 1'b0, val: 1'b0}
                            : dir_drive(dir_bits[1], lat_bits[1]);

        // Pin 2: clock-out > comparator out > timer in > direction
        unique case (p2_src)
            P2_CLKOUT: drv[2] = pin_drv_t'{oe: 1'b1, val: fosc4_val};
            P2_CMPOUT: drv[2] = pin_drv_t'{oe: 1'b1, val: cmp_out};
            P2_TMRIN:  drv[2] = pin_drv_t'{oe: 1'b0, val: 1'b0};
            default:   drv[2] = dir_drive(dir_bits[2], lat_bits[2]);
        endcase

        // Pin 3: input only
        drv[MCLR_PIN] = pin_drv_t'{oe: 1'b0, val: 1'b0};
    end

    always_comb begin
        assert (!drv[MCLR_PIN].oe);
    end
endmodule

// File: rtl/pio_wake.sv
module pio_wake
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins,
    input  logic             rd_en,
    input  logic             sleep,
    input  logic             wake_en_n,
    input  logic             mclr_mode,
    output logic             wake
);
    logic [NPINS-1:0] snap_q;
    logic [NPINS-1:0] mask;
    logic             diff_c;
    logic             diff_q;

    always_comb begin
        mask = GROUP_MASK & {NPINS{~wake_en_n}};
        if (mclr_mode) mask[MCLR_PIN] = 1'b0;
        diff_c = sleep && (|((pins ^ snap_q) & mask));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            diff_q <= 1'b0;
            wake   <= 1'b0;
        end else begin
            if (rd_en) snap_q <= pins;
            diff_q <= diff_c;
            wake   <= diff_c && !diff_q;
        end
    end

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);                                   // R9
    AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (rst)
        wake |-> ($past(sleep) && !$past(wake_en_n)));     // R10
endmodule

// File: rtl/mcu_port_ctrl.sv
module mcu_port_ctrl
    import pio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_we,
    input  logic [REG_W-1:0] dir_wdata,
    input  logic             lat_we,
    input  logic [REG_W-1:0] lat_wdata,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pullup,
    input  logic             pullup_en_n,
    input  logic             wake_en_n,
    input  logic             mclr_mode,
    input  logic             sleep,
    input  logic             cmp_pos_en,
    input  logic             cmp_neg_en,
    input  logic             cmp_out_en,
    input  logic             cmp_out,
    input  logic             fosc4_en,
    input  logic             fosc4_val,
    input  logic             t0ck_en,
    output logic             wake
);
    logic [NPINS-1:0]     dir_q;
    logic [NPINS-1:0]     lat_q;
    logic [NPINS-1:0]     pins_s;
    pin_drv_t [NPINS-1:0] drv_c;
    pin_drv_t [NPINS-1:0] drv_q;
    logic                 unused_hi;

    assign unused_hi = ^{dir_wdata[REG_W-1:NPINS], lat_wdata[REG_W-1:NPINS]};

    // Direction (write-only) and output latch
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
        end else begin
            if (dir_we) dir_q <= dir_wdata[NPINS-1:0];
            if (lat_we) lat_q <= lat_wdata[NPINS-1:0];
        end
    end

    pio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_s)
    );

    pio_pin_mux u_mux (
        .dir_bits   (dir_q),
        .lat_bits   (lat_q),
        .cmp_pos_en (cmp_pos_en),
        .cmp_neg_en (cmp_neg_en),
        .cmp_out_en (cmp_out_en),
        .cmp_out    (cmp_out),
        .fosc4_en   (fosc4_en),
        .fosc4_val  (fosc4_val),
        .t0ck_en    (t0ck_en),
        .drv        (drv_c)
    );

    // Registered pad drive
    always_ff @(posedge clk) begin
        if (rst) drv_q <= '0;
        else     drv_q <= drv_c;
    end

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pad
            assign pin_oe[i]  = drv_q[i].oe;
            assign pin_out[i] = drv_q[i].val;
        end
    endgenerate

    // Read path: pin levels only, upper bits zero
    assign rd_data = {{HI_W{1'b0}}, pins_s};

    // Group weak pull-ups
    always_comb begin
        pin_pullup = GROUP_MASK & {NPINS{~pullup_en_n}};
        if (mclr_mode) pin_pullup[MCLR_PIN] = 1'b1;
    end

    pio_wake u_wake (
        .clk       (clk),
        .rst       (rst),
        .pins      (pins_s),
        .rd_en     (rd_en),
        .sleep     (sleep),
        .wake_en_n (wake_en_n),
        .mclr_mode (mclr_mode),
        .wake      (wake)
    );

    AST_GP3_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !pin_oe[MCLR_PIN]);                                            // R5
    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:NPINS] == '0);                                 // R1
    AST_FOSC4_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fosc4_en)) |-> (pin_oe[2] && pin_out[2] == $past(fosc4_val))); // R7
    AST_CMP_POS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmp_pos_en)) |-> !pin_oe[0]);            // R6
endmodule

// File: tb/mcu_port_ctrl_tb.sv
module mcu_port_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       dir_we, lat_we, rd_en;
    logic [7:0] dir_wdata, lat_wdata, rd_data;
    logic [3:0] pin_in, pin_out, pin_oe, pin_pullup;
    logic       pullup_en_n, wake_en_n, mclr_mode, sleep;
    logic       cmp_pos_en, cmp_neg_en, cmp_out_en, cmp_out;
    logic       fosc4_en, fosc4_val, t0ck_en, wake;
    logic [3:0] ext, hold_low;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad model: driven pins follow pin_out unless held low outside
    assign pin_in = (pin_oe & pin_out & ~hold_low) | (~pin_oe & ext);

    mcu_port_ctrl u_dut (
        .clk(clk), .rst(rst), .dir_we(dir_we), .dir_wdata(dir_wdata),
        .lat_we(lat_we), .lat_wdata(lat_wdata), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
        .pullup_en_n(pullup_en_n), .wake_en_n(wake_en_n), .mclr_mode(mclr_mode),
        .sleep(sleep), .cmp_pos_en(cmp_pos_en), .cmp_neg_en(cmp_neg_en),
        .cmp_out_en(cmp_out_en), .cmp_out(cmp_out), .fosc4_en(fosc4_en),
        .fosc4_val(fosc4_val), .t0ck_en(t0ck_en), .wake(wake)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [3:0] dir, input logic [3:0] lat);
        dir_we = 1; dir_wdata = {4'hF, dir};
        lat_we = 1; lat_wdata = {4'hA, lat};
        step(1);
        dir_we = 0; lat_we = 0;
    endtask

    task automatic snap_read();
        rd_en = 1; step(1); rd_en = 0;
    endtask

    task automatic t_reset();
        rst = 1; step(2); rst = 0;
        check("R4 oe after reset", {4'h0, pin_oe}, 8'h00);
        check("R4 wake after reset", {7'h0, wake}, 8'h00);
        step(2);
        check("R1 read inputs after reset", rd_data, {4'h0, ext});
    endtask

    task automatic t_drive();
        wr_port(4'b0000, 4'b1010);
        check("R2 not yet driven after first edge", {4'h0, pin_oe}, 8'h00);
        step(1);
        check("R3 oe from direction", {4'h0, pin_oe}, 8'h07);
        check("R2 driven values", {5'h0, pin_out[2:0]}, 8'h02);
        step(2);
        check("R1 read loops back pins", rd_data, {4'h0, ext[3], 3'b010});
        lat_we = 1; lat_wdata = 8'hF0; step(1); lat_we = 0;   // upper bits ignored
        step(5);
        check("R2 latch holds", {5'h0, pin_out[2:0]}, 8'h00);
        wr_port(4'b1111, 4'b0101);
        step(1);
        check("R3 direction 1 releases", {4'h0, pin_oe}, 8'h00);
    endtask

    task automatic t_contention();
        wr_port(4'b1110, 4'b0001);
        hold_low = 4'b0001;
        step(3);
        check("R1 driven high held low", {7'h0, rd_data[0]}, 8'h00);
        check("R1 latch still high", {7'h0, pin_out[0]}, 8'h01);
        hold_low = 4'b0000;
        step(2);
        check("R1 released pin reads high", {7'h0, rd_data[0]}, 8'h01);
    endtask

    task automatic t_gp3();
        wr_port(4'b0000, 4'b1111);
        step(1);
        check("R5 pin3 never driven", {7'h0, pin_oe[3]}, 8'h00);
    endtask

    task automatic t_cmp();
        cmp_pos_en = 1; step(1);
        check("R6 pin0 released", {6'h0, pin_oe[1:0]}, 8'h02);
        cmp_pos_en = 0; cmp_neg_en = 1; step(1);
        check("R6 pin1 released", {6'h0, pin_oe[1:0]}, 8'h01);
        cmp_neg_en = 0; step(1);
    endtask

    task automatic t_gp2();
        wr_port(4'b0000, 4'b0000);
        step(1);
        t0ck_en = 1; step(1);
        check("R7 timer input releases pin2", {7'h0, pin_oe[2]}, 8'h00);
        cmp_out_en = 1; cmp_out = 1; step(1);
        check("R7 comparator above timer", {6'h0, pin_oe[2], pin_out[2]}, 8'h03);
        fosc4_en = 1; fosc4_val = 0; step(1);
        check("R7 clock-out above comparator", {6'h0, pin_oe[2], pin_out[2]}, 8'h02);
        fosc4_en = 0; cmp_out_en = 0; t0ck_en = 0; step(1);
        check("R7 direction last", {6'h0, pin_oe[2], pin_out[2]}, 8'h02);
        wr_port(4'b1111, 4'b0000);
        step(1);
    endtask

    task automatic t_pullup();
        check("R8 pullups off", {4'h0, pin_pullup}, 8'h00);
        pullup_en_n = 0; #1;
        check("R8 group pullups", {4'h0, pin_pullup}, 8'h0B);
        pullup_en_n = 1; mclr_mode = 1; #1;
        check("R8 reset-pin pullup forced", {4'h0, pin_pullup}, 8'h08);
        mclr_mode = 0; #1;
    endtask

    task automatic t_wake();
        bit seen;
        ext = 4'b0000; step(3); snap_read();
        sleep = 1; wake_en_n = 0;
        ext[2] = 1; seen = 0;
        for (int i = 0; i < 5; i++) begin step(1); seen |= wake; end
        check("R9 pin2 does not wake", {7'h0, seen}, 8'h00);
        ext[1] = 1;
        step(2);
        check("R9 no wake before third edge", {7'h0, wake}, 8'h00);
        step(1);
        check("R9 wake pulse", {7'h0, wake}, 8'h01);
        step(1);
        check("R9 pulse lasts one cycle", {7'h0, wake}, 8'h00);
        snap_read(); step(1);
        mclr_mode = 1; ext[3] = 1; seen = 0;
        for (int i = 0; i < 5; i++) begin step(1); seen |= wake; end
        check("R9 pin3 excluded in reset-pin mode", {7'h0, seen}, 8'h00);
        mclr_mode = 0; snap_read(); step(1);
        sleep = 0; ext[0] = 1; seen = 0;
        for (int i = 0; i < 5; i++) begin step(1); seen |= wake; end
        check("R10 no wake when awake", {7'h0, seen}, 8'h00);
        sleep = 1; wake_en_n = 1; snap_read(); ext[0] = 0; seen = 0;
        for (int i = 0; i < 5; i++) begin step(1); seen |= wake; end
        check("R10 no wake when disabled", {7'h0, seen}, 8'h00);
        sleep = 0;
    endtask

    initial begin
        rst = 1; dir_we = 0; lat_we = 0; rd_en = 0;
        dir_wdata = 0; lat_wdata = 0;
        pullup_en_n = 1; wake_en_n = 1; mclr_mode = 0; sleep = 0;
        cmp_pos_en = 0; cmp_neg_en = 0; cmp_out_en = 0; cmp_out = 0;
        fosc4_en = 0; fosc4_val = 0; t0ck_en = 0;
        ext = 4'b1001; hold_low = 4'b0000;
        @(negedge clk);
        t_reset();
        t_drive();
        t_contention();
        t_gp3();
        t_cmp();
        t_gp2();
        t_pullup();
        t_wake();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule